// File: doc/BRIEF.md
# Zero-Crossing Synchronised Wiper Commit

This block holds the committed wiper position of each audio channel and moves it to a new target only at a quiet instant. When control logic upstream posts a new target position, every channel is armed. An armed channel waits for a zero-crossing pulse from its own audio path and then copies the target into its own position register. Channels decide on their own, so one channel may update several milliseconds before the other.

A window timer counts millisecond ticks from the post. If a channel has not seen a crossing by the time the window ends, it takes the target anyway, so a silent or DC-biased channel cannot hold a volume change back for ever. Once no channel is left waiting, the block raises a one-cycle done pulse. A post that arrives while channels are still waiting replaces the target, arms every channel again and starts a fresh window.

Top module: `zc_wiper_commit`

## Requirements
- R1: After reset every channel position equals RESET_POS (default 10), busy_o is 0 and done_o is 0.
- R2: A cycle with post_i high captures target_i; from the next cycle busy_o is 1 and every channel is waiting.
- R3: A waiting channel whose zc_i bit is high in a cycle without post_i shows the captured target on its pos_o slice (bits ch*POS_W upward) from the next cycle, and stops waiting.
- R4: A zero-crossing on one channel leaves the position and waiting state of every other channel unchanged.
- R5: Ticks are counted from the post; on the cycle carrying the TIMEOUT_TICKS-th tick (default 32) after the post, every channel still waiting takes the target, and busy_o is 0 from the next cycle.
- R6: done_o is high for exactly one cycle, in the cycle after the last waiting channel commits, and busy_o is 0 in that cycle.
- R7: A post while channels are waiting replaces the target, re-arms every channel (including ones that already committed) and restarts the tick count from zero.
- R8: A zero-crossing pulse on a channel that is not waiting leaves its position unchanged.
- R9: A zero-crossing or window expiry in the same cycle as post_i commits nothing; the post takes effect instead.
- R10: Ticks arriving while no channel is waiting do not shorten the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_i | input | 1 | Strobe: capture target_i and arm all channels |
| target_i | input | POS_W | New wiper position |
| zc_i | input | N_CH | Zero-crossing pulse per channel, bit ch for channel ch |
| tick_i | input | 1 | Millisecond tick, one cycle wide |
| pos_o | output | N_CH*POS_W | Committed positions, channel ch in bits [ch*POS_W +: POS_W] |
| busy_o | output | 1 | At least one channel is waiting to commit |
| done_o | output | 1 | One-cycle pulse when the last waiting channel has committed |

## Verification
The hardest situations to reach are the coincidences at the edge of the window: a new post landing on exactly the tick that would have expired the old window, and a crossing arriving in the same cycle as a post. The stimulus counts ticks from each post so that a re-post is placed on the 32nd tick, and separately drives post and crossing together. A long run of random posts, crossings and ticks, with crossings rare enough that both the crossing path and the expiry path are taken, is compared every clock against a behavioural model.

// File: rtl/zcw_pkg.sv
// Shared types for the zero-crossing wiper commit block.
// Assumes nothing beyond being compiled before the modules that import it.
package zcw_pkg;

    // Per-channel commit state.
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_WAIT = 1'b1
    } ch_state_e;

endpackage

// File: rtl/zcw_window_timer.sv
// Window timer: counts tick pulses from the most recent restart while run_i is
// high and flags expiry on the TIMEOUT_TICKS-th tick. A restart in the same
// cycle suppresses expiry. Assumes TIMEOUT_TICKS >= 2 and one-cycle ticks.
module zcw_window_timer #(
    parameter int TIMEOUT_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Expiry fires on the final tick of a running, not-restarted window.
    assign expire_o = run_i && !restart_i && tick_i && (cnt_q == LAST);

    // Tick counter: cleared on restart or expiry, advanced on ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/zcw_channel.sv
// One channel's commit stage: armed by a post, it copies the shared target into
// its position register on its own zero-crossing or on window expiry, whichever
// comes first. Assumes arm_i has priority over every commit cause.
module zcw_channel
    import zcw_pkg::*;
#(
    parameter int POS_W     = 5,
    parameter int RESET_POS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             expire_i,
    input  logic             zc_i,
    input  logic [POS_W-1:0] target_i,
    output logic             pend_o,
    output logic             commit_o,
    output logic [POS_W-1:0] pos_o
);

    ch_state_e        state_q;
    logic [POS_W-1:0] pos_q;

    assign pend_o   = (state_q == CH_WAIT);
    // A commit happens this cycle when waiting, not re-armed, and a cause is present.
    assign commit_o = pend_o && !arm_i && (zc_i || expire_i);
    assign pos_o    = pos_q;

    // State and position: arm wins, otherwise commit on crossing or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            pos_q   <= POS_W'(RESET_POS);
        end else if (arm_i) begin
            state_q <= CH_WAIT;
        end else if (commit_o) begin
            state_q <= CH_IDLE;
            pos_q   <= target_i;
        end
    end

    p_commit_zc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !arm_i && zc_i) |=> (!pend_o && pos_q == $past(target_i)));

    p_idle_ignores_zc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !arm_i) |=> ($stable(pos_q) && !pend_o));

    p_arm_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (pend_o && $stable(pos_q)));

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !zc_i && !expire_i) |=> (pend_o && $stable(pos_q)));

endmodule

// File: rtl/zc_wiper_commit.sv
// Zero-crossing synchronised wiper commit for N_CH channels. Captures a posted
// target, arms every channel, runs a shared tick window and pulses done when no
// channel is left waiting. Assumes zero-crossing and tick inputs are one-cycle
// pulses synchronous to clk.
module zc_wiper_commit #(
    parameter int POS_W         = 5,
    parameter int N_CH          = 2,
    parameter int TIMEOUT_TICKS = 32,
    parameter int RESET_POS     = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_i,
    input  logic [POS_W-1:0]      target_i,
    input  logic [N_CH-1:0]       zc_i,
    input  logic                  tick_i,
    output logic [N_CH*POS_W-1:0] pos_o,
    output logic                  busy_o,
    output logic                  done_o
);

    logic [POS_W-1:0] target_q;
    logic [N_CH-1:0]  pend;
    logic [N_CH-1:0]  commit;
    logic             expire;
    logic             last_clear;
    logic             done_q;

    assign busy_o     = |pend;
    // Every waiting channel commits this cycle and no new post arrives.
    assign last_clear = busy_o && !post_i && ((pend & ~commit) == '0);
    assign done_o     = done_q;

    // Target capture on post.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= POS_W'(RESET_POS);
        end else if (post_i) begin
            target_q <= target_i;
        end
    end

    // Done pulse register, high the cycle after the last commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_clear;
        end
    end

    zcw_window_timer #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(post_i),
        .run_i    (busy_o),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [POS_W-1:0] ch_pos;

        zcw_channel #(
            .POS_W    (POS_W),
            .RESET_POS(RESET_POS)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm_i   (post_i),
            .expire_i(expire),
            .zc_i    (zc_i[g]),
            .target_i(target_q),
            .pend_o  (pend[g]),
            .commit_o(commit[g]),
            .pos_o   (ch_pos)
        );

        assign pos_o[g*POS_W +: POS_W] = ch_pos;
    end

    p_post_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        post_i |=> ((&pend) && busy_o && target_q == $past(target_i)));

    p_repost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && post_i) |=> ((&pend) && target_q == $past(target_i)));

    p_expire_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !busy_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

// File: tb/zc_wiper_commit_tb.sv
// Bench: behavioural model updated on every rising edge, compared with the
// design on every falling edge; inputs are driven on the falling edge.
module zc_wiper_commit_tb;

    localparam int POS_W = 5;
    localparam int T     = 32;
    localparam int RPOS  = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             post_i = 1'b0;
    logic [POS_W-1:0] target_i = '0;
    logic [1:0]       zc_i = '0;
    logic             tick_i = 1'b0;
    logic [2*POS_W-1:0] pos_o;
    logic             busy_o;
    logic             done_o;

    int tests = 0;
    int fails = 0;
    string phase = "R1 reset";

    // Model state
    int m_pos [2];
    bit m_pend [2];
    int m_tgt;
    int m_cnt;
    bit m_done;

    always #4 clk = ~clk;

    zc_wiper_commit #(
        .POS_W(POS_W), .N_CH(2), .TIMEOUT_TICKS(T), .RESET_POS(RPOS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .post_i(post_i), .target_i(target_i),
        .zc_i(zc_i), .tick_i(tick_i), .pos_o(pos_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    // Reference model, evaluated at each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos[0] = RPOS; m_pos[1] = RPOS;
            m_pend[0] = 0; m_pend[1] = 0;
            m_tgt = RPOS; m_cnt = 0; m_done = 0;
        end else begin
            bit was_busy;
            bit exp;
            was_busy = m_pend[0] || m_pend[1];
            exp = was_busy && !post_i && tick_i && (m_cnt == T - 1);
            if (post_i) begin
                m_tgt = int'(target_i);
                m_pend[0] = 1; m_pend[1] = 1;
                m_cnt = 0;
            end else begin
                if (was_busy && tick_i) m_cnt = exp ? 0 : m_cnt + 1;
                for (int c = 0; c < 2; c++) begin
                    if (m_pend[c] && (zc_i[c] || exp)) begin
                        m_pos[c] = m_tgt;
                        m_pend[c] = 0;
                    end
                end
            end
            m_done = was_busy && !post_i && !m_pend[0] && !m_pend[1];
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare();
        chk(int'(pos_o[POS_W-1:0]) == m_pos[0], "pos ch0", int'(pos_o[POS_W-1:0]), m_pos[0]);
        chk(int'(pos_o[2*POS_W-1:POS_W]) == m_pos[1], "pos ch1", int'(pos_o[2*POS_W-1:POS_W]), m_pos[1]);
        chk(busy_o == (m_pend[0] || m_pend[1]), "busy", int'(busy_o), int'(m_pend[0] || m_pend[1]));
        chk(done_o == m_done, "done", int'(done_o), int'(m_done));
    endtask

    // One cycle: check results of the last edge, then drive the next inputs.
    task automatic step(input bit p, input int t, input bit [1:0] z, input bit tk);
        @(negedge clk);
        compare();
        post_i   = p;
        target_i = POS_W'(t);
        zc_i     = z;
        tick_i   = tk;
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(1'b0, 0, 2'b00, tk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in phase %s: actual hung expected finished", phase);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        phase = "R1 reset";
        step(0, 0, 2'b00, 0);
        chk(pos_o == {POS_W'(RPOS), POS_W'(RPOS)}, "reset pos", int'(pos_o), RPOS);
        chk(!busy_o && !done_o, "reset flags", int'({busy_o, done_o}), 0);

        // R2 / R3 / R4 / R6: crossings on each channel at different times
        phase = "R2 post arms";
        step(1, 20, 2'b00, 0);
        step(0, 0, 2'b00, 0);
        chk(busy_o == 1'b1, "busy after post", int'(busy_o), 1);
        phase = "R3 zero-crossing commit";
        idle(3, 1);
        step(0, 0, 2'b01, 0);
        phase = "R4 channel independence";
        step(0, 0, 2'b00, 0);
        chk(int'(pos_o[POS_W-1:0]) == 20 && int'(pos_o[2*POS_W-1:POS_W]) == RPOS,
            "ch0 moved alone", int'(pos_o), 20);
        idle(4, 0);
        phase = "R6 done pulse";
        step(0, 0, 2'b10, 0);
        step(0, 0, 2'b00, 0);
        chk(done_o == 1'b1 && busy_o == 1'b0, "done after last", int'({done_o, busy_o}), 2);
        step(0, 0, 2'b00, 0);
        chk(done_o == 1'b0, "done single cycle", int'(done_o), 0);

        // R5: no crossings, window expires on the T-th tick
        phase = "R5 timeout";
        step(1, 3, 2'b00, 0);
        for (int i = 0; i < T; i++) begin
            step(0, 0, 2'b00, 1);
            step(0, 0, 2'b00, 0);
        end
        step(0, 0, 2'b00, 0);
        chk(pos_o == {POS_W'(3), POS_W'(3)} && !busy_o, "forced commit", int'(pos_o), 99);

        // R4 / R5: one channel crosses, the other is forced
        phase = "R4 mixed crossing and expiry";
        step(1, 7, 2'b00, 0);
        step(0, 0, 2'b10, 1);
        for (int i = 0; i < T; i++) step(0, 0, 2'b00, 1);
        idle(2, 0);
        chk(pos_o == {POS_W'(7), POS_W'(7)}, "both at 7", int'(pos_o), 231);

        // R7: re-post on exactly the tick that would expire the window
        phase = "R7 repost restarts window";
        step(1, 12, 2'b00, 0);
        step(0, 0, 2'b00, 0);
        for (int i = 0; i < T - 1; i++) step(0, 0, 2'b00, 1);
        step(1, 25, 2'b00, 1);
        step(0, 0, 2'b00, 0);
        chk(busy_o && pos_o == {POS_W'(7), POS_W'(7)}, "no commit on repost", int'(pos_o), 231);
        for (int i = 0; i < T - 1; i++) step(0, 0, 2'b00, 1);
        step(0, 0, 2'b00, 0);
        chk(busy_o == 1'b1, "still waiting after T-1 ticks", int'(busy_o), 1);
        step(0, 0, 2'b00, 1);
        step(0, 0, 2'b00, 0);
        chk(!busy_o && pos_o == {POS_W'(25), POS_W'(25)}, "new target committed", int'(pos_o), 825);

        // R7: re-post re-arms an already committed channel
        phase = "R7 rearm committed channel";
        step(1, 2, 2'b00, 0);
        step(0, 0, 2'b01, 0);
        step(1, 30, 2'b00, 0);
        step(0, 0, 2'b00, 0);
        step(0, 0, 2'b11, 0);
        step(0, 0, 2'b00, 0);
        chk(pos_o == {POS_W'(30), POS_W'(30)}, "both at 30", int'(pos_o), 990);

        // R8 / R10: crossings and ticks while idle
        phase = "R8 idle crossings ignored";
        for (int i = 0; i < 20; i++) step(0, 0, 2'(i), 1);
        step(0, 0, 2'b00, 0);
        chk(pos_o == {POS_W'(30), POS_W'(30)} && !busy_o, "idle unchanged", int'(pos_o), 990);
        phase = "R10 idle ticks not counted";
        step(1, 31, 2'b00, 0);
        for (int i = 0; i < T - 1; i++) step(0, 0, 2'b00, 1);
        step(0, 0, 2'b00, 0);
        chk(busy_o == 1'b1, "full window after idle ticks", int'(busy_o), 1);
        step(0, 0, 2'b00, 1);
        idle(2, 0);

        // R8: crossing on committed channel while the other still waits
        phase = "R8 committed channel ignores crossing";
        step(1, 0, 2'b00, 0);
        step(0, 0, 2'b01, 0);
        step(0, 0, 2'b00, 0);
        step(0, 0, 2'b01, 0);
        step(0, 0, 2'b00, 0);
        chk(int'(pos_o[POS_W-1:0]) == 0 && busy_o, "ch0 stays, ch1 waits", int'(pos_o), 0);
        step(0, 0, 2'b10, 0);

        // R9: crossing in the same cycle as a post
        phase = "R9 post wins over crossing";
        step(1, 15, 2'b11, 0);
        step(0, 0, 2'b00, 0);
        chk(busy_o && int'(pos_o[POS_W-1:0]) == 0, "no commit with post", int'(pos_o[POS_W-1:0]), 0);
        step(0, 0, 2'b11, 0);
        step(0, 0, 2'b00, 0);

        // R2 / R3 / R5 / R7: random traffic against the model
        phase = "R3 random traffic";
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 60) == 0, $urandom % 32,
                 {($urandom % 25) == 0, ($urandom % 25) == 0}, ($urandom % 2) == 0);
        end
        idle(2, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule